// File: doc/BRIEF.md
# Page-Load Flash Write Controller

This block is the write front end of a byte-wide parallel flash. A host drives active-low chip-enable, write-enable and output-enable strobes together with an address and a data byte. While both enables are low and output-enable is high, the write strobe is considered active. Each active strobe loads one byte into a page buffer. The byte offset is taken when the strobe becomes active. The data byte is taken when the strobe ends.

A page load window opens with the first byte. It stays open for as long as each new strobe starts soon enough after the previous one ended. When no new strobe starts within the timeout, the buffered page is committed to a behavioural storage array. Any offset that was not loaded in the window is written with a fixed marker value. The block then reports busy for a fixed number of write cycles. During that time reads return a polling word instead of array data, and write strobes are ignored.

All strobes are sampled in the block clock domain and are assumed to be synchronous to it. Both the timeout and the write-cycle length are counted in clock cycles.

Top module: `page_flash_writer`

## Requirements
- R1: After synchronous reset, busy is 0, no load window is open, and dout is 0 while no read is requested.
- R2: A byte load starts only when ce_n and we_n are both 0 and oe_n is 1. A strobe made with oe_n at 0 opens no window, and busy stays 0.
- R3: The offset within the page is addr[5:0], taken at the start of the strobe. The data byte is din, taken at the end of the strobe. Bytes may be loaded in any order.
- R4: The page number is addr[ADDR_W-1:6] of the first byte of a window. The upper address bits of later bytes in the same window are ignored.
- R5: When LOAD_TIMEOUT clock edges pass after a strobe ends without a new strobe starting, the window closes and busy rises. A strobe that starts on the LOAD_TIMEOUT-th edge keeps the window open.
- R6: busy stays high for exactly WRITE_CYCLES cycles. A strobe that arrives while busy is high loads nothing and opens no new window.
- R7: A read while busy returns a polling word. Bit 7 of that word is the inverse of bit 7 of the last byte loaded, and bits 6..0 are 0.
- R8: After busy falls, each loaded offset of the committed page reads back its byte. Each offset that was not loaded reads the marker 0xFF. Other pages keep their contents.
- R9: A read is served only when ce_n is 0, oe_n is 0 and we_n is 1. Otherwise dout is 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Block clock |
| rst | input | 1 | Synchronous active-high reset |
| ce_n | input | 1 | Chip enable, active low |
| we_n | input | 1 | Write enable, active low |
| oe_n | input | 1 | Output enable, active low |
| addr | input | ADDR_W | Byte address; page in the upper bits, offset in the low 6 bits |
| din | input | DATA_W | Write data byte |
| dout | output | DATA_W | Read data, polling word while busy, 0 when no read is requested |
| busy | output | 1 | Internal write cycle in progress |

## Verification
The bench builds the block with an 8-bit address (four pages of 64 bytes), a load timeout of 6 cycles and a write cycle of 20 cycles. With the timeout this short, the bench can place strobes on the exact last edge of the window and on the first edge after it. The small array also lets the bench read back every offset of each committed page after each commit. Gaps between strobes sweep every value from 0 to one below the timeout, so the start of busy and its length can be counted edge by edge.

// File: rtl/pfl_pkg.sv
package pfl_pkg;

    localparam int BYTE_W = 8;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_LOAD = 2'd1,
        ST_PROG = 2'd2
    } wr_state_e;

    typedef struct packed {
        logic act;   // strobe active this cycle
        logic fall;  // strobe became active
        logic rise;  // strobe ended
    } strobe_ev_t;

    function automatic logic strobe_on(input logic ce_n, input logic we_n, input logic oe_n);
        return !ce_n && !we_n && oe_n;
    endfunction

    function automatic logic read_on(input logic ce_n, input logic we_n, input logic oe_n);
        return !ce_n && !oe_n && we_n;
    endfunction

endpackage

// File: rtl/pfl_strobe.sv
module pfl_strobe
    import pfl_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic       ce_n,
    input  logic       we_n,
    input  logic       oe_n,
    output strobe_ev_t ev
);
    logic act_now;
    logic act_q;

    assign act_now = strobe_on(ce_n, we_n, oe_n);

    always_ff @(posedge clk) begin
        if (rst) act_q <= 1'b0;
        else     act_q <= act_now;
    end

    always_comb begin
        ev.act  = act_now;
        ev.fall = act_now && !act_q;
        ev.rise = !act_now && act_q;
    end
endmodule

// File: rtl/pfl_page_buf.sv
module pfl_page_buf #(
    parameter int PAGE_BITS = 6,
    parameter int DATA_W    = 8,
    localparam int PAGE_SIZE = 1 << PAGE_BITS
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 clear,
    input  logic                 wr_en,
    input  logic [PAGE_BITS-1:0] wr_off,
    input  logic [DATA_W-1:0]    wr_data,
    output logic [DATA_W-1:0]    bytes_o [PAGE_SIZE],
    output logic [PAGE_SIZE-1:0] loaded_o
);
    for (genvar g = 0; g < PAGE_SIZE; g++) begin : g_slot
        logic hit;
        assign hit = wr_en && (wr_off == PAGE_BITS'(g));

        always_ff @(posedge clk) begin
            if (rst || clear) begin
                loaded_o[g] <= 1'b0;
                bytes_o[g]  <= '0;
            end else if (hit) begin
                loaded_o[g] <= 1'b1;
                bytes_o[g]  <= wr_data;
            end
        end
    end
endmodule

// File: rtl/pfl_array.sv
module pfl_array #(
    parameter int ADDR_W    = 10,
    parameter int PAGE_BITS = 6,
    parameter int DATA_W    = 8,
    parameter logic [DATA_W-1:0] UNLOADED = '1,
    localparam int PAGE_SIZE = 1 << PAGE_BITS,
    localparam int PAGE_W    = ADDR_W - PAGE_BITS,
    localparam int DEPTH     = 1 << ADDR_W
) (
    input  logic                 clk,
    input  logic                 commit,
    input  logic [PAGE_W-1:0]    commit_page,
    input  logic [DATA_W-1:0]    bytes_i [PAGE_SIZE],
    input  logic [PAGE_SIZE-1:0] loaded_i,
    input  logic [ADDR_W-1:0]    rd_addr,
    output logic [DATA_W-1:0]    rd_data
);
    logic [DATA_W-1:0] mem [DEPTH];

    always_ff @(posedge clk) begin
        if (commit) begin
            for (int i = 0; i < PAGE_SIZE; i++) begin
                mem[{commit_page, PAGE_BITS'(i)}] <= loaded_i[i] ? bytes_i[i] : UNLOADED;
            end
        end
    end

    assign rd_data = mem[rd_addr];
endmodule

// File: rtl/page_flash_writer.sv
module page_flash_writer
    import pfl_pkg::*;
#(
    parameter int ADDR_W       = 10,
    parameter int PAGE_BITS    = 6,
    parameter int DATA_W       = BYTE_W,
    parameter int LOAD_TIMEOUT = 1200,
    parameter int WRITE_CYCLES = 5000,
    parameter logic [DATA_W-1:0] UNLOADED = '1
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              ce_n,
    input  logic              we_n,
    input  logic              oe_n,
    input  logic [ADDR_W-1:0] addr,
    input  logic [DATA_W-1:0] din,
    output logic [DATA_W-1:0] dout,
    output logic              busy
);
    localparam int PAGE_SIZE = 1 << PAGE_BITS;
    localparam int PAGE_W    = ADDR_W - PAGE_BITS;
    localparam int GAP_W     = $clog2(LOAD_TIMEOUT + 1);
    localparam int WC_W      = $clog2(WRITE_CYCLES + 1);

    wr_state_e            st;
    strobe_ev_t           ev;
    logic [PAGE_W-1:0]    page_q;
    logic [PAGE_BITS-1:0] off_q;
    logic                 last_msb_q;
    logic [GAP_W-1:0]     gap_q;
    logic [WC_W-1:0]      wc_q;
    logic                 loading;
    logic                 buf_clear;
    logic                 buf_wr;
    logic                 commit;
    logic                 rd_req;
    logic [DATA_W-1:0]    bytes   [PAGE_SIZE];
    logic [PAGE_SIZE-1:0] loaded;
    logic [DATA_W-1:0]    arr_data;
    logic [DATA_W-1:0]    poll_word;

    pfl_strobe u_strobe (
        .clk  (clk),
        .rst  (rst),
        .ce_n (ce_n),
        .we_n (we_n),
        .oe_n (oe_n),
        .ev   (ev)
    );

    pfl_page_buf #(
        .PAGE_BITS (PAGE_BITS),
        .DATA_W    (DATA_W)
    ) u_buf (
        .clk      (clk),
        .rst      (rst),
        .clear    (buf_clear),
        .wr_en    (buf_wr),
        .wr_off   (off_q),
        .wr_data  (din),
        .bytes_o  (bytes),
        .loaded_o (loaded)
    );

    pfl_array #(
        .ADDR_W    (ADDR_W),
        .PAGE_BITS (PAGE_BITS),
        .DATA_W    (DATA_W),
        .UNLOADED  (UNLOADED)
    ) u_array (
        .clk         (clk),
        .commit      (commit),
        .commit_page (page_q),
        .bytes_i     (bytes),
        .loaded_i    (loaded),
        .rd_addr     (addr),
        .rd_data     (arr_data)
    );

    assign loading   = (st == ST_LOAD);
    assign busy      = (st == ST_PROG);
    assign buf_clear = (st == ST_IDLE) && ev.fall;
    assign buf_wr    = loading && ev.rise;
    // window closes only on a quiet cycle whose gap count has reached its limit
    assign commit    = loading && !ev.act && !ev.rise
                       && (gap_q == GAP_W'(LOAD_TIMEOUT - 1));

    always_ff @(posedge clk) begin
        if (rst) begin
            st         <= ST_IDLE;
            page_q     <= '0;
            off_q      <= '0;
            last_msb_q <= 1'b0;
            gap_q      <= '0;
            wc_q       <= '0;
        end else begin
            unique case (st)
                ST_IDLE: begin
                    if (ev.fall) begin
                        st     <= ST_LOAD;
                        page_q <= addr[ADDR_W-1:PAGE_BITS];
                        off_q  <= addr[PAGE_BITS-1:0];
                        gap_q  <= '0;
                    end
                end
                ST_LOAD: begin
                    if (ev.fall) off_q <= addr[PAGE_BITS-1:0];
                    if (buf_wr) last_msb_q <= din[DATA_W-1];
                    if (ev.act || ev.rise) begin
                        gap_q <= '0;
                    end else if (commit) begin
                        st   <= ST_PROG;
                        wc_q <= '0;
                    end else begin
                        gap_q <= gap_q + 1'b1;
                    end
                end
                ST_PROG: begin
                    if (wc_q == WC_W'(WRITE_CYCLES - 1)) st <= ST_IDLE;
                    else                                  wc_q <= wc_q + 1'b1;
                end
                default: st <= ST_IDLE;
            endcase
        end
    end

    assign poll_word = {~last_msb_q, {(DATA_W-1){1'b0}}};
    assign rd_req    = read_on(ce_n, we_n, oe_n);

    always_comb begin
        if (!rd_req)   dout = '0;
        else if (busy) dout = poll_word;
        else           dout = arr_data;
    end
endmodule

// File: rtl/page_flash_writer_chk.sv
module page_flash_writer_chk #(
    parameter int DATA_W       = 8,
    parameter int WRITE_CYCLES = 5000
) (
    input logic              clk,
    input logic              rst,
    input logic              ce_n,
    input logic              we_n,
    input logic              oe_n,
    input logic [DATA_W-1:0] dout,
    input logic              busy,
    input logic              loading
);
    localparam int RUN_W = $clog2(WRITE_CYCLES + 2);

    logic [RUN_W-1:0] run;
    logic             rd_seen;
    logic             wr_seen;

    assign rd_seen = !ce_n && !oe_n && we_n;
    assign wr_seen = !ce_n && !we_n && oe_n;

    always_ff @(posedge clk) begin
        if (rst)       run <= '0;
        else if (busy) run <= run + 1'b1;
        else           run <= '0;
    end

    // R6
    busy_len_chk: assert property (@(posedge clk) disable iff (rst)
        busy |-> (run < RUN_W'(WRITE_CYCLES)));

    // R6
    busy_full_chk: assert property (@(posedge clk) disable iff (rst)
        $fell(busy) |-> (run == RUN_W'(WRITE_CYCLES)));

    // R5
    busy_start_chk: assert property (@(posedge clk) disable iff (rst)
        $rose(busy) |-> ($past(loading) && !$past(wr_seen)));

    // R7
    poll_low_chk: assert property (@(posedge clk) disable iff (rst)
        (busy && rd_seen) |-> (dout[DATA_W-2:0] == '0));

    // R9
    rd_gate_chk: assert property (@(posedge clk) disable iff (rst)
        !rd_seen |-> (dout == '0));
endmodule

bind page_flash_writer page_flash_writer_chk #(
    .DATA_W       (DATA_W),
    .WRITE_CYCLES (WRITE_CYCLES)
) u_chk (
    .clk     (clk),
    .rst     (rst),
    .ce_n    (ce_n),
    .we_n    (we_n),
    .oe_n    (oe_n),
    .dout    (dout),
    .busy    (busy),
    .loading (loading)
);

// File: tb/test_page_flash_writer.sv
`timescale 1ns/1ps
module test_page_flash_writer;
    localparam int AW = 8;
    localparam int TO = 6;
    localparam int WC = 20;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       ce_n = 1'b1, we_n = 1'b1, oe_n = 1'b1;
    logic [7:0] addr = '0;
    logic [7:0] din = '0;
    logic [7:0] dout;
    logic       busy;
    int         tests = 0;
    int         fails = 0;

    always #4 clk = ~clk;

    page_flash_writer #(
        .ADDR_W       (AW),
        .PAGE_BITS    (6),
        .DATA_W       (8),
        .LOAD_TIMEOUT (TO),
        .WRITE_CYCLES (WC),
        .UNLOADED     (8'hFF)
    ) i_page_flash_writer (
        .clk (clk), .rst (rst), .ce_n (ce_n), .we_n (we_n), .oe_n (oe_n),
        .addr (addr), .din (din), .dout (dout), .busy (busy)
    );

    task automatic check(input string req, input int act, input int exp);
        tests++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    function automatic logic [7:0] pat1(input int a);
        return 8'((a * 29 + 5) & 8'hFF);
    endfunction

    function automatic logic [7:0] pat2(input int a);
        return 8'(a) ^ 8'h5A;
    endfunction

    task automatic bus_idle();
        ce_n = 1'b1; we_n = 1'b1; oe_n = 1'b1;
    endtask

    // called at a falling clock edge; returns one falling edge after release
    task automatic put_byte(input logic [7:0] a, input logic [7:0] d, input logic oe_val);
        addr = a; din = d; ce_n = 1'b0; we_n = 1'b0; oe_n = oe_val;
        @(negedge clk); @(negedge clk);
        ce_n = 1'b1; we_n = 1'b1; oe_n = 1'b1;
        @(negedge clk);
    endtask

    task automatic read_byte(input logic [7:0] a, output logic [7:0] d);
        addr = a; ce_n = 1'b0; oe_n = 1'b0; we_n = 1'b1;
        #1 d = dout;
        @(negedge clk);
    endtask

    // called one falling edge after the last strobe release
    task automatic close_window(input logic [7:0] last_byte, input string tag);
        int cnt;
        int b;
        cnt = 0;
        while (!busy && cnt < 100) begin
            @(negedge clk);
            cnt++;
        end
        check({"R5 window close delay ", tag}, cnt, TO);
        addr = 8'h00; ce_n = 1'b0; oe_n = 1'b0; we_n = 1'b1;
        #1 check({"R7 polling word ", tag}, dout, {~last_byte[7], 7'b0});
        b = 0;
        while (busy && b < 1000) begin
            b++;
            @(negedge clk);
        end
        check({"R6 busy length ", tag}, b, WC);
        bus_idle();
        @(negedge clk);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        fails++;
        $display("FAIL watchdog expired");
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    initial begin
        logic [7:0] d;
        repeat (3) @(negedge clk);
        // R1 reset state
        check("R1 busy in reset", busy, 0);
        check("R1 dout idle in reset", dout, 0);
        rst = 1'b0;
        @(negedge clk);
        check("R1 busy after reset", busy, 0);
        check("R1 dout idle after reset", dout, 0);

        // R3 full page 1, reverse order
        for (int o = 63; o >= 0; o--) put_byte(8'(64 + o), pat1(64 + o), 1'b1);
        check("R5 no busy right after last byte", busy, 0);
        close_window(pat1(64), "page1");
        for (int o = 0; o < 64; o++) begin
            read_byte(8'(64 + o), d);
            check("R3 R8 page1 readback", d, pat1(64 + o));
        end
        bus_idle(); @(negedge clk);

        // R4 R5 page 2 even offsets, later bytes carry page-1 upper bits, gaps swept
        put_byte(8'd128, pat2(128), 1'b1);
        for (int k = 1; k < 32; k++) begin
            repeat (k % TO) @(negedge clk);
            put_byte(8'(64 + 2 * k), pat2(128 + 2 * k), 1'b1);
        end
        repeat (TO - 1) @(negedge clk);
        check("R5 window open at last edge", busy, 0);
        put_byte(8'd64 + 8'd62, pat2(190), 1'b1);
        close_window(pat2(190), "page2");
        for (int o = 0; o < 64; o++) begin
            read_byte(8'(128 + o), d);
            check("R8 page2 readback", d, (o % 2 == 0) ? int'(pat2(128 + o)) : 8'hFF);
        end
        for (int o = 0; o < 64; o++) begin
            read_byte(8'(64 + o), d);
            check("R4 page1 untouched", d, pat1(64 + o));
        end
        bus_idle(); @(negedge clk);

        // R6 strobe one edge too late lands during busy and is ignored
        put_byte(8'd192 + 8'd9, 8'hC3, 1'b1);
        repeat (TO) @(negedge clk);
        check("R5 busy one edge past window", busy, 1);
        put_byte(8'd192 + 8'd10, 8'h11, 1'b1);
        while (busy) @(negedge clk);
        bus_idle();
        repeat (TO + 4) @(negedge clk);
        check("R6 no window from ignored strobe", busy, 0);
        for (int o = 0; o < 64; o++) begin
            read_byte(8'(192 + o), d);
            check("R6 R8 page3 readback", d, (o == 9) ? 8'hC3 : 8'hFF);
        end
        bus_idle(); @(negedge clk);

        // R2 strobe with output enable low does nothing
        put_byte(8'd64, 8'h00, 1'b0);
        repeat (TO + 4) @(negedge clk);
        check("R2 no window with oe_n low", busy, 0);
        read_byte(8'd64, d);
        check("R2 page1 byte kept", d, pat1(64));

        // R9 read gating
        addr = 8'd65; ce_n = 1'b1; oe_n = 1'b0; we_n = 1'b1;
        #1 check("R9 ce_n high gives zero", dout, 0);
        @(negedge clk);
        ce_n = 1'b0; oe_n = 1'b1; we_n = 1'b1;
        #1 check("R9 oe_n high gives zero", dout, 0);
        @(negedge clk);
        bus_idle(); @(negedge clk);

        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end
endmodule